// File: doc/BRIEF.md
# PHY Lane Register Initialization Sequencer

This block is a small master that brings up the lane registers of two PHYs through their parallel control-register ports. Each PHY has its own port made of a select line, a 16-bit address, a 16-bit write-data bus, a write enable and an acknowledge input. A one-cycle start pulse makes the block raise both selects and wait a settle period. It then writes one fixed initialization word into four lane registers on each PHY, for eight writes in total.

Every write is a four-phase handshake. The address and data are presented first, then write enable rises. The block waits for acknowledge to go high, drops write enable, and waits for acknowledge to fall. Each wait has its own cycle limit. A PHY that does not answer within the limit sets a sticky warning flag, and the sequence carries on with the next phase instead of stopping. After the eighth write completes, a one-cycle done pulse is given and the block returns to idle.

Top module: `phy_lane_init_seq`

## Requirements
- R1: While reset is held low, and in the cycle after it is released, every select, write enable, address and write-data output is zero, and warn_o and done_o are low.
- R2: A start pulse accepted in idle raises every bit of sel_o, and sel_o stays high from then on. No write enable rises until sel_o has been high for at least SETTLE_CYC (default 10) cycles.
- R3: A write drives its address and data at least one cycle before write enable rises and holds them steady while it is high. Write enable falls only after acknowledge has been seen high or the timeout has expired. The next write begins only after acknowledge has been seen low or the timeout has expired.
- R4: Each acknowledge wait lasts at most TIMEOUT cycles (default 32). If acknowledge does not go high, write enable stays high for exactly TIMEOUT cycles, then falls. Expiry of either wait sets warn_o, and the sequence still performs all eight writes.
- R5: At most one PHY has write enable high at any time. The address and write data of the PHY that is not being written are zero.
- R6: warn_o is sticky. It stays high through idle cycles and is cleared only in the cycle in which a new start is accepted.
- R7: The lane register address is 0x1008 + 0x100 × lane, for lanes 0 to 3. The eight writes go to PHY 0 lanes 0, 1, 2, 3, then PHY 1 lanes 0, 1, 2, 3.
- R8: Every write carries the word 0x0E21. This word sets bit 0 (clock-data recovery tracking), bit 5 (loss-of-signal threshold), bit 9 (termination on), bit 10 (AC-coupled termination) and bit 11 (PHY on). All other bits are clear.
- R9: done_o is high for exactly one cycle, after the eighth handshake has finished. The block then idles and accepts a new start.
- R10: A start pulse that arrives while a sequence is running is ignored. No extra writes are made and no extra done pulse is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control-port clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to run the initialization sequence |
| sel_o | output | NPHY | Register-port select for each PHY |
| addr_o | output | NPHY×16 | Register address for each PHY |
| wdata_o | output | NPHY×16 | Write data for each PHY |
| wen_o | output | NPHY | Write enable for each PHY |
| ack_i | input | NPHY | Acknowledge from each PHY |
| warn_o | output | 1 | Sticky flag: an acknowledge wait timed out |
| done_o | output | 1 | One-cycle pulse when the eighth write has finished |

## Verification
The hardest situations to reach are the timeout exits. The rise timeout happens only when a PHY never answers. The fall timeout happens only when acknowledge is stuck high, so the rise phase completes at once and the release phase never does. The bench reaches both with a behavioural PHY responder whose mode is set per PHY for each run: delayed echo, always low, or always high. The table of runs pairs each mode setting with the warning it must produce and checks the write-enable high time against the limit. A second start pulse is fired in every run while writes are in flight, and a reset is applied in the middle of a sequence.

// File: rtl/pli_pkg.sv
// Package: shared state encodings for the PHY lane initialization sequencer.
// Assumes: both sequencer and handshake engine import these types.
package pli_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SETTLE,
        SQ_ISSUE,
        SQ_WAIT,
        SQ_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_PRE,
        HS_RISE,
        HS_FALL
    } hs_state_e;

endpackage

// File: rtl/pli_handshake.sv
// Module: four-phase write handshake engine with a per-phase timeout.
// Runs one write per go pulse: one setup cycle with enable low, enable high
// until ack rises (or TIMEOUT cycles), then enable low until ack falls
// (or TIMEOUT cycles). fin_o and tmo_o are single-cycle combinational pulses.
// Assumes: go_i is only raised while the engine is idle; ack_i is already
// routed from the PHY being written.
module pli_handshake #(
    parameter int TIMEOUT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic ack_i,
    output logic wen_o,
    output logic fin_o,
    output logic tmo_o
);
    import pli_pkg::*;

    localparam int TW = $clog2(TIMEOUT + 1);
    localparam logic [TW-1:0] LAST = TW'(TIMEOUT - 1);

    hs_state_e     state;
    logic [TW-1:0] wait_cnt;
    logic          expired;

    assign expired = (wait_cnt == LAST);

    // Phase register and wait counter for the current write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= HS_IDLE;
            wait_cnt <= '0;
        end else begin
            case (state)
                HS_IDLE: begin
                    wait_cnt <= '0;
                    if (go_i) state <= HS_PRE;
                end
                HS_PRE: begin
                    state <= HS_RISE;
                end
                HS_RISE: begin
                    if (ack_i || expired) begin
                        state    <= HS_FALL;
                        wait_cnt <= '0;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                HS_FALL: begin
                    if (!ack_i || expired) begin
                        state    <= HS_IDLE;
                        wait_cnt <= '0;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                default: state <= HS_IDLE;
            endcase
        end
    end

    // Enable, completion and timeout strobes decoded from the phase.
    always_comb begin
        wen_o = (state == HS_RISE);
        fin_o = (state == HS_FALL) && (!ack_i || expired);
        tmo_o = ((state == HS_RISE) && !ack_i && expired) ||
                ((state == HS_FALL) &&  ack_i && expired);
    end

endmodule

// File: rtl/pli_sequencer.sv
// Module: walks the lane/PHY write order and owns select, warning and done.
// After an accepted start it raises select, waits SETTLE_CYC cycles, then
// issues one handshake per lane, PHY 0 lanes ascending before PHY 1.
// Assumes: SETTLE_CYC >= 1; NPHY and NLANE are powers of two >= 2.
module pli_sequencer #(
    parameter int NPHY       = 2,
    parameter int NLANE      = 4,
    parameter int SETTLE_CYC = 10,
    parameter int PW         = $clog2(NPHY),
    parameter int LW         = $clog2(NLANE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          fin_i,
    input  logic          tmo_i,
    output logic          go_o,
    output logic          xfer_o,
    output logic [PW-1:0] phy_idx_o,
    output logic [LW-1:0] lane_idx_o,
    output logic          sel_o,
    output logic          warn_o,
    output logic          done_o
);
    import pli_pkg::*;

    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);

    seq_state_e    state;
    logic [SW-1:0] settle_cnt;
    logic          last_write;

    assign last_write = (phy_idx_o == PW'(NPHY - 1)) && (lane_idx_o == LW'(NLANE - 1));

    // Sequence state, write index, select and sticky warning.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SQ_IDLE;
            settle_cnt <= '0;
            phy_idx_o  <= '0;
            lane_idx_o <= '0;
            sel_o      <= 1'b0;
            warn_o     <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start_i) begin
                        state      <= SQ_SETTLE;
                        sel_o      <= 1'b1;
                        warn_o     <= 1'b0;
                        settle_cnt <= '0;
                        phy_idx_o  <= '0;
                        lane_idx_o <= '0;
                    end
                end
                SQ_SETTLE: begin
                    if (settle_cnt == SETTLE_LAST) state <= SQ_ISSUE;
                    else                           settle_cnt <= settle_cnt + 1'b1;
                end
                SQ_ISSUE: begin
                    state <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (fin_i) begin
                        if (last_write) begin
                            state <= SQ_DONE;
                        end else begin
                            state <= SQ_ISSUE;
                            if (lane_idx_o == LW'(NLANE - 1)) begin
                                lane_idx_o <= '0;
                                phy_idx_o  <= phy_idx_o + 1'b1;
                            end else begin
                                lane_idx_o <= lane_idx_o + 1'b1;
                            end
                        end
                    end
                end
                SQ_DONE: begin
                    state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
            if (tmo_i) warn_o <= 1'b1;
        end
    end

    // Handshake launch, transfer window and completion pulse.
    always_comb begin
        go_o   = (state == SQ_ISSUE);
        xfer_o = (state == SQ_ISSUE) || (state == SQ_WAIT);
        done_o = (state == SQ_DONE);
    end

endmodule

// File: rtl/pli_port_drive.sv
// Module: fans the single active write out to the per-PHY register ports.
// Only the PHY being written sees a non-zero address, data and enable; the
// acknowledge of that PHY is routed back to the handshake engine.
// Assumes: lane address = LANE_BASE + LANE_STRIDE * lane fits in AW bits.
module pli_port_drive #(
    parameter int              NPHY        = 2,
    parameter int              NLANE       = 4,
    parameter int              AW          = 16,
    parameter int              DW          = 16,
    parameter logic [AW-1:0]   LANE_BASE   = 16'h1008,
    parameter logic [AW-1:0]   LANE_STRIDE = 16'h0100,
    parameter logic [DW-1:0]   INIT_WORD   = 16'h0E21,
    parameter int              PW          = $clog2(NPHY),
    parameter int              LW          = $clog2(NLANE)
) (
    input  logic                     xfer_i,
    input  logic [PW-1:0]            phy_idx_i,
    input  logic [LW-1:0]            lane_idx_i,
    input  logic                     wen_i,
    input  logic                     sel_i,
    input  logic [NPHY-1:0]          ack_i,
    output logic [NPHY-1:0]          sel_o,
    output logic [NPHY-1:0][AW-1:0]  addr_o,
    output logic [NPHY-1:0][DW-1:0]  wdata_o,
    output logic [NPHY-1:0]          wen_o,
    output logic                     ack_sel_o
);
    logic [AW-1:0] lane_addr;

    // Register address of the lane currently being written.
    always_comb begin
        lane_addr = LANE_BASE + (AW'(lane_idx_i) * LANE_STRIDE);
    end

    // Route acknowledge of the active PHY; none outside a transfer.
    always_comb begin
        ack_sel_o = xfer_i ? ack_i[phy_idx_i] : 1'b0;
    end

    for (genvar g = 0; g < NPHY; g++) begin : g_phy
        logic active;
        assign active = xfer_i && (phy_idx_i == PW'(g));

        // Per-PHY port outputs: driven only while this PHY is addressed.
        always_comb begin
            sel_o[g]   = sel_i;
            addr_o[g]  = active ? lane_addr : '0;
            wdata_o[g] = active ? INIT_WORD : '0;
            wen_o[g]   = active && wen_i;
        end
    end

endmodule

// File: rtl/phy_lane_init_seq.sv
// Module: top of the PHY lane register initialization sequencer.
// Joins the write-order sequencer, the four-phase handshake engine and the
// per-PHY port fan-out. Assumes one control-port clock for all PHY ports.
module phy_lane_init_seq #(
    parameter int            NPHY        = 2,
    parameter int            NLANE       = 4,
    parameter int            AW          = 16,
    parameter int            DW          = 16,
    parameter int            SETTLE_CYC  = 10,
    parameter int            TIMEOUT     = 32,
    parameter logic [AW-1:0] LANE_BASE   = 16'h1008,
    parameter logic [AW-1:0] LANE_STRIDE = 16'h0100,
    parameter logic [DW-1:0] INIT_WORD   = 16'h0E21
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    output logic [NPHY-1:0]         sel_o,
    output logic [NPHY-1:0][AW-1:0] addr_o,
    output logic [NPHY-1:0][DW-1:0] wdata_o,
    output logic [NPHY-1:0]         wen_o,
    input  logic [NPHY-1:0]         ack_i,
    output logic                    warn_o,
    output logic                    done_o
);
    localparam int PW = $clog2(NPHY);
    localparam int LW = $clog2(NLANE);

    logic          go, xfer, sel_all, hs_wen, hs_fin, hs_tmo, ack_sel;
    logic [PW-1:0] phy_idx;
    logic [LW-1:0] lane_idx;

    pli_sequencer #(
        .NPHY(NPHY), .NLANE(NLANE), .SETTLE_CYC(SETTLE_CYC), .PW(PW), .LW(LW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .fin_i(hs_fin), .tmo_i(hs_tmo),
        .go_o(go), .xfer_o(xfer), .phy_idx_o(phy_idx), .lane_idx_o(lane_idx),
        .sel_o(sel_all), .warn_o(warn_o), .done_o(done_o)
    );

    pli_handshake #(.TIMEOUT(TIMEOUT)) u_hs (
        .clk(clk), .rst_n(rst_n), .go_i(go), .ack_i(ack_sel),
        .wen_o(hs_wen), .fin_o(hs_fin), .tmo_o(hs_tmo)
    );

    pli_port_drive #(
        .NPHY(NPHY), .NLANE(NLANE), .AW(AW), .DW(DW),
        .LANE_BASE(LANE_BASE), .LANE_STRIDE(LANE_STRIDE), .INIT_WORD(INIT_WORD),
        .PW(PW), .LW(LW)
    ) u_drv (
        .xfer_i(xfer), .phy_idx_i(phy_idx), .lane_idx_i(lane_idx),
        .wen_i(hs_wen), .sel_i(sel_all), .ack_i(ack_i),
        .sel_o(sel_o), .addr_o(addr_o), .wdata_o(wdata_o), .wen_o(wen_o),
        .ack_sel_o(ack_sel)
    );

endmodule

// File: rtl/pli_checker.sv
// Module: protocol checker for phy_lane_init_seq, attached with bind.
// Tracks its own run window and per-PHY enable-high time from the ports.
module pli_checker #(
    parameter int NPHY       = 2,
    parameter int AW         = 16,
    parameter int DW         = 16,
    parameter int SETTLE_CYC = 10,
    parameter int TIMEOUT    = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_i,
    input logic [NPHY-1:0]         sel_o,
    input logic [NPHY-1:0][AW-1:0] addr_o,
    input logic [NPHY-1:0][DW-1:0] wdata_o,
    input logic [NPHY-1:0]         wen_o,
    input logic [NPHY-1:0]         ack_i,
    input logic                    warn_o,
    input logic                    done_o
);
    logic run;
    int   since_start;
    int   hi_cnt [NPHY];

    // Run window and saturating cycle count since the accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run         <= 1'b0;
            since_start <= 0;
        end else if (start_i && !run) begin
            run         <= 1'b1;
            since_start <= 0;
        end else begin
            if (done_o) run <= 1'b0;
            if (since_start < SETTLE_CYC) since_start <= since_start + 1;
        end
    end

    // R2: write enable only while every select is high.
    p_sel_before_wen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|wen_o) |-> (&sel_o));

    // R2: first enable rise no sooner than the settle time after start.
    p_settle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|wen_o) |-> (since_start >= SETTLE_CYC));

    // R5: never two PHYs written at once.
    p_onehot_wen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wen_o));

    // R6: warning holds unless a start arrives.
    p_warn_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_o && !start_i) |=> warn_o);

    // R9: done is a single-cycle pulse.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    for (genvar g = 0; g < NPHY; g++) begin : g_chk
        // Consecutive cycles this PHY's enable has already been high.
        always_ff @(posedge clk) begin
            if (!rst_n)         hi_cnt[g] <= 0;
            else if (wen_o[g])  hi_cnt[g] <= hi_cnt[g] + 1;
            else                hi_cnt[g] <= 0;
        end

        // R3: address and data steady while enable stays high.
        p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (wen_o[g] && $past(wen_o[g])) |-> ($stable(addr_o[g]) && $stable(wdata_o[g])));

        // R3: enable falls only after ack seen high or the limit was reached.
        p_fall_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(wen_o[g]) |-> ($past(ack_i[g]) || ($past(hi_cnt[g]) == TIMEOUT - 1)));

        // R4: enable never stays high longer than the timeout.
        p_timeout_r4: assert property (@(posedge clk) disable iff (!rst_n)
            wen_o[g] |-> (hi_cnt[g] < TIMEOUT));
    end

endmodule

bind phy_lane_init_seq pli_checker #(
    .NPHY(NPHY), .AW(AW), .DW(DW), .SETTLE_CYC(SETTLE_CYC), .TIMEOUT(TIMEOUT)
) u_pli_checker (.*);

// File: tb/phy_lane_init_seq_bench.sv
module phy_lane_init_seq_bench;
    localparam int NPHY   = 2;
    localparam int AW     = 16;
    localparam int DW     = 16;
    localparam int TMO    = 32;
    localparam int SETTLE = 10;

    // Expected writes in order: {phy, address, data} (R7, R8).
    localparam logic [32:0] EXP_WR [8] = '{
        {1'b0, 16'h1008, 16'h0E21}, {1'b0, 16'h1108, 16'h0E21},
        {1'b0, 16'h1208, 16'h0E21}, {1'b0, 16'h1308, 16'h0E21},
        {1'b1, 16'h1008, 16'h0E21}, {1'b1, 16'h1108, 16'h0E21},
        {1'b1, 16'h1208, 16'h0E21}, {1'b1, 16'h1308, 16'h0E21}
    };
    // Runs: {expected warn, mode0[1:0], delay0[2:0], mode1[1:0], delay1[2:0]}.
    // Mode 0 = echo enable after delay, 1 = never acknowledge, 2 = stuck high.
    localparam logic [10:0] RUNS [5] = '{
        {1'b0, 2'd0, 3'd0, 2'd0, 3'd0},
        {1'b0, 2'd0, 3'd5, 2'd0, 3'd2},
        {1'b1, 2'd1, 3'd0, 2'd0, 3'd1},
        {1'b1, 2'd0, 3'd3, 2'd2, 3'd0},
        {1'b0, 2'd0, 3'd7, 2'd0, 3'd7}
    };

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    start_i = 1'b0;
    logic [NPHY-1:0]         sel_o;
    logic [NPHY-1:0][AW-1:0] addr_o;
    logic [NPHY-1:0][DW-1:0] wdata_o;
    logic [NPHY-1:0]         wen_o;
    logic [NPHY-1:0]         ack_i;
    logic                    warn_o;
    logic                    done_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    phy_lane_init_seq u_phy_lane_init_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_o(sel_o),
        .addr_o(addr_o), .wdata_o(wdata_o), .wen_o(wen_o), .ack_i(ack_i),
        .warn_o(warn_o), .done_o(done_o)
    );

    // Behavioural PHY responders.
    logic [1:0] rmode [NPHY];
    logic [2:0] rdly  [NPHY];
    logic [7:0] sr    [NPHY];
    always @(posedge clk) begin
        for (int i = 0; i < NPHY; i++) begin
            if (!rst_n) begin
                sr[i]    <= '0;
                ack_i[i] <= 1'b0;
            end else begin
                sr[i] <= {sr[i][6:0], wen_o[i]};
                case (rmode[i])
                    2'd0:    ack_i[i] <= sr[i][rdly[i]];
                    2'd1:    ack_i[i] <= 1'b0;
                    default: ack_i[i] <= 1'b1;
                endcase
            end
        end
    end

    // Port monitors, sampled at the falling edge.
    logic [32:0]             log_e [32];
    int                      log_n = 0;
    int                      hi [NPHY];
    int                      max_hi [NPHY];
    int                      done_cnt = 0, done_b2b = 0, pre_cnt = 0;
    int                      hs_viol = 0, r5_viol = 0;
    bit                      seen_wen = 1'b0;
    logic [NPHY-1:0]         wen_q = '0, ack_q = '0;
    logic                    done_q = 1'b0;
    logic [NPHY-1:0][AW-1:0] addr_q = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NPHY; i++) begin
                if (wen_o[i] && !wen_q[i] && log_n < 32) begin
                    log_e[log_n] = {i[0], addr_o[i], wdata_o[i]};
                    log_n++;
                end
                if (wen_o[i] && !wen_q[i] && ack_i[i] && rmode[i] == 2'd0) hs_viol++;
                if (!wen_o[i] && wen_q[i] && !ack_q[i] && rmode[i] == 2'd0) hs_viol++;
                if (wen_o[i] && wen_q[i] && addr_o[i] != addr_q[i]) hs_viol++;
                if (wen_o[i]) begin
                    hi[i]++;
                    if (hi[i] > max_hi[i]) max_hi[i] = hi[i];
                    for (int j = 0; j < NPHY; j++)
                        if (j != i && (wen_o[j] || addr_o[j] != '0 || wdata_o[j] != '0)) r5_viol++;
                end else begin
                    hi[i] = 0;
                end
            end
            if (done_o) done_cnt++;
            if (done_o && done_q) done_b2b++;
            if ((&sel_o) && !seen_wen && !(|wen_o)) pre_cnt++;
            if (|wen_o) seen_wen = 1'b1;
        end
        wen_q  = wen_o;
        ack_q  = ack_i;
        addr_q = addr_o;
        done_q = done_o;
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: act %0d cycles exp below 150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act 0x%0h exp 0x%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic wait_done(input int base);
        for (int k = 0; k < 4000 && done_cnt == base; k++) @(negedge clk);
    endtask

    task automatic check_idle_outputs(input string req);
        chk(sel_o == '0, req, sel_o, 0);
        chk(wen_o == '0 && addr_o == '0 && wdata_o == '0, req, {wen_o, addr_o}, 0);
        chk(!warn_o && !done_o, req, {warn_o, done_o}, 0);
    endtask

    initial begin
        for (int i = 0; i < NPHY; i++) begin
            rmode[i] = 2'd0; rdly[i] = 3'd0; hi[i] = 0; max_hi[i] = 0;
        end
        repeat (3) @(negedge clk);
        check_idle_outputs("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle_outputs("R1 after reset");

        for (int r = 0; r < 5; r++) begin
            bit exp_warn;
            int base;
            exp_warn = RUNS[r][10];
            rmode[0] = RUNS[r][9:8]; rdly[0] = RUNS[r][7:5];
            rmode[1] = RUNS[r][4:3]; rdly[1] = RUNS[r][2:0];
            repeat (4) @(negedge clk);
            log_n = 0; hs_viol = 0; r5_viol = 0; done_b2b = 0;
            for (int i = 0; i < NPHY; i++) max_hi[i] = 0;
            base = done_cnt;
            pulse_start();
            chk(warn_o == 1'b0, "R6 warn cleared by start", warn_o, 0);
            chk(sel_o == '1, "R2 select raised", sel_o, 2'b11);
            repeat (30) @(negedge clk);
            start_i = 1'b1;            // R10: start while busy
            @(negedge clk) start_i = 1'b0;
            wait_done(base);
            repeat (40) @(negedge clk);
            chk(done_cnt == base + 1, "R9/R10 one done per run", done_cnt - base, 1);
            chk(done_b2b == 0, "R9 done width", done_b2b, 0);
            chk(log_n == 8, "R10 exactly eight writes", log_n, 8);
            for (int k = 0; k < 8; k++)
                chk(log_e[k] == EXP_WR[k], "R7/R8 write order and word", log_e[k], EXP_WR[k]);
            chk(warn_o == exp_warn, "R4 warning flag", warn_o, exp_warn);
            chk(r5_viol == 0, "R5 inactive port quiet", r5_viol, 0);
            chk(addr_o == '0 && wen_o == '0, "R5 idle ports zero", addr_o, 0);
            chk(sel_o == '1, "R2 select held", sel_o, 2'b11);
            if (r == 0) chk(pre_cnt >= SETTLE, "R2 settle before first write", pre_cnt, SETTLE);
            for (int i = 0; i < NPHY; i++) begin
                if (rmode[i] == 2'd1)
                    chk(max_hi[i] == TMO, "R4 enable high for timeout", max_hi[i], TMO);
                else
                    chk(max_hi[i] <= 10, "R3 enable drops after ack", max_hi[i], 10);
                if (rmode[i] == 2'd0)
                    chk(hs_viol == 0, "R3 four-phase order", hs_viol, 0);
            end
            if (exp_warn) begin
                for (int i = 0; i < NPHY; i++) begin
                    rmode[i] = 2'd0; rdly[i] = 3'd0;
                end
                repeat (20) @(negedge clk);
                chk(warn_o == 1'b1, "R6 warning sticky while idle", warn_o, 1);
            end
        end

        // R1: reset in the middle of a sequence.
        pulse_start();
        repeat (25) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_idle_outputs("R1 reset mid-sequence");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        summary();
        $finish;
    end
endmodule